// File: doc/BRIEF.md
# Demodulated symbol bit serializer

This block sits after the symbol decision stage of a phase-shift-keyed receiver. Once per symbol it is handed a hard I-channel decision and a hard Q-channel decision, marked by a one-cycle symbol strobe. It turns them into a serial bit stream with a one-cycle valid pulse per bit. It also drives a registered I line and a registered Q line that hold the current symbol's decisions.

A two-bit format word picks one of four formats. The two four-phase formats send both bits of every symbol, I first or Q first. The two two-phase formats send a single bit per symbol, taken from either the I decision or the Q decision. A polarity control inverts the serial bits and both channel lines together. The format word and the polarity control are captured only at the symbol strobe, so a change made between strobes cannot split a symbol.

Serial bits leave on the bit-clock enable cycles that follow the strobe, one bit per enable. A new strobe discards any bits of the previous symbol that have not yet been sent.

Top module: `sym_bit_serializer`

## Requirements
- R1: While `rst_n` is low, `ser_bit`, `ser_valid`, `ch_i` and `ch_q` are all 0 after the next clock edge.
- R2: With `mode` = 2'b00 at the strobe, the symbol yields two serial bits: the I bit first, then the Q bit.
- R3: With `mode` = 2'b01 at the strobe, the symbol yields two serial bits: the Q bit first, then the I bit.
- R4: With `mode` = 2'b10 at the strobe, the symbol yields exactly one serial bit, equal to the I bit.
- R5: With `mode` = 2'b11 at the strobe, the symbol yields exactly one serial bit, equal to the Q bit.
- R6: When `invert` is 1 at the strobe, every serial bit of that symbol and both `ch_i` and `ch_q` are the complement of the decisions.
- R7: `ch_i` and `ch_q` take the (possibly inverted) decisions one cycle after a strobe cycle and hold them at every other time.
- R8: A serial bit is issued one cycle after a cycle in which `bit_en` is high, no strobe is present and bits remain. `ser_valid` is high for exactly that cycle, and `ser_bit` holds its value between bits.
- R9: Changes of `mode` or `invert` between strobes have no effect on the bits of the symbol in progress.
- R10: A strobe drops any unsent bits of the previous symbol, and no bit is issued in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | Symbol strobe, one cycle per symbol |
| sym_i | input | 1 | Hard I-channel decision |
| sym_q | input | 1 | Hard Q-channel decision |
| mode | input | 2 | Format: 00 IQ, 01 QI, 10 I only, 11 Q only |
| invert | input | 1 | Output polarity inversion |
| bit_en | input | 1 | Bit-clock enable |
| ser_bit | output | 1 | Serial data bit |
| ser_valid | output | 1 | Serial bit valid pulse |
| ch_i | output | 1 | Registered I-channel output |
| ch_q | output | 1 | Registered Q-channel output |

## Verification
Every output of the block is one register stage from its inputs. The channel lines therefore change in the cycle after a strobe, and each serial bit appears in the cycle after the enable that released it. The bench applies each input set half a period before a rising edge. It advances its behavioural model with those inputs at that edge and compares all four outputs at the following falling edge, so every result is checked in exactly the cycle it is due. Random decisions, random enable gaps and format or polarity changes made between strobes are run in all four formats.

// File: rtl/sym_bit_serializer.sv
module sym_bit_serializer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_valid,
  input  logic       sym_i,
  input  logic       sym_q,
  input  logic [1:0] mode,
  input  logic       invert,
  input  logic       bit_en,
  output logic       ser_bit,
  output logic       ser_valid,
  output logic       ch_i,
  output logic       ch_q
);

  logic [1:0] seq, seq_n;
  logic [1:0] left, left_n;
  logic       bi, bq;

  assign bi = sym_i ^ invert;
  assign bq = sym_q ^ invert;

  always_comb begin
    case (mode)
      2'b00:   begin seq_n = {bq, bi};   left_n = 2'd2; end
      2'b01:   begin seq_n = {bi, bq};   left_n = 2'd2; end
      2'b10:   begin seq_n = {1'b0, bi}; left_n = 2'd1; end
      default: begin seq_n = {1'b0, bq}; left_n = 2'd1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq       <= '0;
      left      <= '0;
      ser_bit   <= 1'b0;
      ser_valid <= 1'b0;
      ch_i      <= 1'b0;
      ch_q      <= 1'b0;
    end else if (sym_valid) begin
      seq       <= seq_n;
      left      <= left_n;
      ch_i      <= bi;
      ch_q      <= bq;
      ser_valid <= 1'b0;
    end else if (bit_en && left != 2'd0) begin
      ser_bit   <= seq[0];
      seq       <= {1'b0, seq[1]};
      left      <= left - 2'd1;
      ser_valid <= 1'b1;
    end else begin
      ser_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sym_bit_serializer_chk.sv
module sym_bit_serializer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_valid,
  input logic       sym_i,
  input logic       sym_q,
  input logic [1:0] mode,
  input logic       invert,
  input logic       bit_en,
  input logic       ser_valid,
  input logic       ch_i,
  input logic       ch_q
);

  logic [1:0] nvalid;
  logic       one_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nvalid  <= '0;
      one_bit <= 1'b0;
    end else if (sym_valid) begin
      nvalid  <= '0;
      one_bit <= mode[1];
    end else if (ser_valid && nvalid != 2'd3) begin
      nvalid  <= nvalid + 2'd1;
    end
  end

  p_valid_after_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> ($past(bit_en) && !$past(sym_valid)));

  p_no_bit_after_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sym_valid) |-> !ser_valid);

  p_ch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sym_valid) && $past(rst_n)) |-> ($stable(ch_i) && $stable(ch_q)));

  p_ch_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sym_valid) && $past(rst_n)) |->
      (ch_i == ($past(sym_i) ^ $past(invert)) && ch_q == ($past(sym_q) ^ $past(invert))));

  p_single_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid && one_bit) |-> nvalid == 2'd0);

  p_two_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> nvalid < 2'd2);

endmodule

bind sym_bit_serializer sym_bit_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_i(sym_i), .sym_q(sym_q),
  .mode(mode), .invert(invert), .bit_en(bit_en), .ser_valid(ser_valid),
  .ch_i(ch_i), .ch_q(ch_q)
);

// File: tb/sym_bit_serializer_bench.sv
`timescale 1ns/1ps
module sym_bit_serializer_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_valid = 1'b0, sym_i = 1'b0, sym_q = 1'b0, invert = 1'b0, bit_en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic ser_bit, ser_valid, ch_i, ch_q;

  always #2 clk = ~clk;

  sym_bit_serializer u_sym_bit_serializer (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_i(sym_i), .sym_q(sym_q),
    .mode(mode), .invert(invert), .bit_en(bit_en),
    .ser_bit(ser_bit), .ser_valid(ser_valid), .ch_i(ch_i), .ch_q(ch_q)
  );

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;
  string req = "R1";

  logic e_bit = 1'b0, e_val = 1'b0, e_i = 1'b0, e_q = 1'b0;
  logic pend[$];

  task automatic cmp(input string name, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, name, act, exp, $time);
    end
  endtask

  task automatic model();
    logic a, b;
    if (!rst_n) begin
      e_bit = 0; e_val = 0; e_i = 0; e_q = 0; pend.delete();
    end else if (sym_valid) begin
      a = sym_i ^ invert; b = sym_q ^ invert;
      pend.delete();
      if (mode == 2'b00) begin pend.push_back(a); pend.push_back(b); end
      else if (mode == 2'b01) begin pend.push_back(b); pend.push_back(a); end
      else if (mode == 2'b10) pend.push_back(a);
      else pend.push_back(b);
      e_i = a; e_q = b; e_val = 0;
    end else if (bit_en && pend.size() > 0) begin
      e_bit = pend.pop_front(); e_val = 1;
    end else begin
      e_val = 0;
    end
  endtask

  task automatic step(input logic sv, input logic [1:0] m, input logic inv, input logic en);
    sym_valid = sv; mode = m; invert = inv; bit_en = en;
    sym_i = 1'($urandom); sym_q = 1'($urandom);
    @(posedge clk);
    model();
    @(negedge clk);
    cmp("ser_valid", ser_valid, e_val);
    cmp("ser_bit", ser_bit, e_bit);
    cmp("ch_i", ch_i, e_i);
    cmp("ch_q", ch_q, e_q);
  endtask

  task automatic symbols(input int n, input logic [1:0] m, input int inv_sel,
                         input int gap, input bit sparse_en, input bit wiggle);
    for (int s = 0; s < n; s++) begin
      logic inv;
      inv = (inv_sel == 2) ? 1'($urandom) : 1'(inv_sel);
      step(1'b1, m, inv, 1'($urandom));
      for (int g = 0; g < gap; g++)
        step(1'b0, wiggle ? 2'($urandom) : m, wiggle ? 1'($urandom) : inv,
             sparse_en ? 1'($urandom) : 1'b1);
    end
  endtask

  initial begin
    @(negedge clk);
    req = "R1";
    for (int k = 0; k < 4; k++) step(1'b0, 2'($urandom), 1'($urandom), 1'($urandom));
    rst_n = 1'b1;
    req = "R2"; symbols(40, 2'b00, 0, 3, 0, 0);
    req = "R3"; symbols(40, 2'b01, 0, 3, 0, 0);
    req = "R4"; symbols(40, 2'b10, 0, 2, 0, 0);
    req = "R5"; symbols(40, 2'b11, 0, 2, 0, 0);
    for (int m = 0; m < 4; m++) begin
      req = "R6"; symbols(30, 2'(m), 2, 3, 0, 0);
    end
    for (int m = 0; m < 4; m++) begin
      req = "R8"; symbols(30, 2'(m), 2, 6, 1, 0);
    end
    for (int m = 0; m < 4; m++) begin
      req = "R9"; symbols(30, 2'(m), 2, 4, 1, 1);
    end
    for (int m = 0; m < 4; m++) begin
      req = "R10"; symbols(30, 2'(m), 2, 1, 0, 0);
      symbols(20, 2'(m), 2, 0, 0, 0);
    end
    req = "R7";
    symbols(20, 2'b00, 2, 8, 1, 1);
    for (int k = 0; k < 10; k++) step(1'b0, 2'($urandom), 1'($urandom), 1'($urandom));
    req = "R1";
    rst_n = 1'b0;
    step(1'b1, 2'b00, 1'b1, 1'b1);
    step(1'b0, 2'b00, 1'b0, 1'b1);
    rst_n = 1'b1;
    step(1'b0, 2'b00, 1'b0, 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule